// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Condition Evaluator

This block is a 64-bit integer execution slice. It adds, subtracts or bitwise-ANDs two operands and presents the result in the same cycle. A per-operation set-flags input chooses whether the four status bits are captured into a small flag register at the next rising clock edge. When set-flags is low, the register keeps the flags from the last flag-setting operation, so a later conditional step still tests those flags.

A width select narrows an operation to the low 32 bits. A destination-is-zero-register input suppresses the register write enable while still allowing a flag update. This gives compare (subtract with flags, result discarded) and test (AND with flags, result discarded).

A combinational evaluator reads the stored flags and a 4-bit condition code. It drives a single taken/not-taken output that a branch unit or a conditional select can use.

Top module: `fx_flag_alu`

## Requirements
- R1: `res` is combinational from the inputs: ADD gives `a+b` modulo 2^64, SUB gives `a-b` modulo 2^64, AND gives `a & b`.
- R2: Operation encoding on `op_sel`: 2'b00 is ADD, 2'b01 is SUB, 2'b10 and 2'b11 are both AND.
- R3: When `set_flags` is 0 at a rising edge, the stored flags keep their value; when it is 1, they take the flags of the current operation at that edge.
- R4: Z is 1 exactly when the (width-masked) result is zero; N equals the result's top bit (bit 63, or bit 31 in 32-bit mode).
- R5: For ADD, C is the unsigned carry out and V is signed overflow. For SUB, C is 1 when no borrow occurs (a >= b unsigned), and V is signed overflow of a-b.
- R6: A flag-setting AND clears both C and V.
- R7: With `w32`=1, only bits [31:0] of the operands are used, `res[63:32]` is zero, and C/V come from the 32-bit operation.
- R8: `wr_en` is the inverse of `dst_zr`; with `dst_zr`=1 the flags still update when `set_flags` is 1 (compare and test forms).
- R9: `flags` packs N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. Condition codes are 0 EQ (Z), 1 NE (!Z), 2 CS (C), 3 CC (!C), 4 MI (N), 5 PL (!N), 6 VS (V), 7 VC (!V), 8 HI (C&!Z), 9 LS (!C|Z), 10 GE (N==V), 11 LT (N!=V), 12 GT (!Z&N==V), 13 LE (Z|N!=V), and 14 and 15 are always true.
- R10: A synchronous active-high `rst` clears the stored flags to 0000 at the rising edge.
- R11: `cond_true` is combinational from the stored flags and `cond`: it reflects the new flags right after the update edge and follows a change of `cond` with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_sel | input | 2 | Operation select (00 add, 01 sub, 1x and) |
| set_flags | input | 1 | Capture this operation's flags at the next edge |
| w32 | input | 1 | 1 selects 32-bit operation on the low halves |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| dst_zr | input | 1 | Destination is the zero register; result discarded |
| cond | input | 4 | Condition code to evaluate |
| res | output | 64 | Operation result |
| wr_en | output | 1 | Register write enable for the result |
| flags | output | 4 | Stored flags {N,Z,C,V} |
| cond_true | output | 1 | Condition holds for the stored flags |

## Verification
`res` and `wr_en` are due in the same cycle as the operands. The bench drives on the falling edge and samples them one nanosecond later, before any rising edge. The stored flags, and any `cond_true` that depends on them, change only at the rising edge after a set-flags operation. The bench therefore samples them one nanosecond after that edge, and repeats the sample after a non-flag-setting operation to show that nothing moved. Condition sweeps hold the flags fixed and change only `cond`, sampling each code after a short settle delay with no clock edge between codes.

// File: rtl/fx_flag_pkg.sv
`timescale 1ns/1ps
package fx_flag_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_AND  = 2'b10,
    OP_AND2 = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Condition evaluation: bits [3:1] pick the base test, bit 0 inverts it,
  // except for the always-true pair at 3'b111.
  function automatic logic cond_holds(input logic [3:0] code, input nzcv_t f);
    logic base;
    unique case (code[3:1])
      3'd0: base = f.z;
      3'd1: base = f.c;
      3'd2: base = f.n;
      3'd3: base = f.v;
      3'd4: base = f.c & ~f.z;
      3'd5: base = (f.n == f.v);
      3'd6: base = ~f.z & (f.n == f.v);
      default: base = 1'b1;
    endcase
    if (code[3:1] == 3'd7) return 1'b1;
    return code[0] ? ~base : base;
  endfunction

endpackage

// File: rtl/fx_arith.sv
`timescale 1ns/1ps
module fx_arith
  import fx_flag_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  alu_op_e         op,
  input  logic            w32,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output nzcv_t           flg_nxt,
  output logic            is_logic_op
);
  localparam int HW  = XLEN / 2;
  localparam int WP1 = XLEN + 1;
  localparam int HP1 = HW + 1;

  // Full-width adder with carry-in; returns {carry, sum}.
  function automatic logic [WP1-1:0] add_full(input logic [XLEN-1:0] x,
                                              input logic [XLEN-1:0] y,
                                              input logic ci);
    return {1'b0, x} + {1'b0, y} + WP1'(ci);
  endfunction

  // Half-width adder with carry-in; returns {carry, sum}.
  function automatic logic [HP1-1:0] add_half(input logic [HW-1:0] x,
                                              input logic [HW-1:0] y,
                                              input logic ci);
    return {1'b0, x} + {1'b0, y} + HP1'(ci);
  endfunction

  // Signed overflow: operands agree in sign, result disagrees.
  function automatic logic ovf(input logic sx, input logic sy, input logic sr);
    return (sx == sy) && (sr != sx);
  endfunction

  logic            sub_op;
  logic [XLEN-1:0] b_eff;
  logic [WP1-1:0]  sum_w;
  logic [HP1-1:0]  sum_h;
  logic [XLEN-1:0] and_w;
  logic            c_arith;
  logic            v_arith;
  logic            msb;

  assign sub_op      = (op == OP_SUB);
  assign is_logic_op = op[1];
  assign b_eff       = sub_op ? ~b : b;
  assign sum_w       = add_full(a, b_eff, sub_op);
  assign sum_h       = add_half(a[HW-1:0], b_eff[HW-1:0], sub_op);
  assign and_w       = a & b;

  always_comb begin
    if (is_logic_op) begin
      res = w32 ? {{HW{1'b0}}, and_w[HW-1:0]} : and_w;
    end else if (w32) begin
      res = {{HW{1'b0}}, sum_h[HW-1:0]};
    end else begin
      res = sum_w[XLEN-1:0];
    end
  end

  always_comb begin
    if (w32) begin
      c_arith = sum_h[HW];
      v_arith = ovf(a[HW-1], b_eff[HW-1], sum_h[HW-1]);
      msb     = res[HW-1];
    end else begin
      c_arith = sum_w[XLEN];
      v_arith = ovf(a[XLEN-1], b_eff[XLEN-1], sum_w[XLEN-1]);
      msb     = res[XLEN-1];
    end
  end

  always_comb begin
    flg_nxt.n = msb;
    flg_nxt.z = (res == '0);
    flg_nxt.c = is_logic_op ? 1'b0 : c_arith;
    flg_nxt.v = is_logic_op ? 1'b0 : v_arith;
  end

  // R7: narrow mode never leaks into the upper half
  always_comb begin
    if (w32) a_r7_upper_zero: assert (res[XLEN-1:HW] == '0);
  end

endmodule

// File: rtl/fx_flag_reg.sv
`timescale 1ns/1ps
module fx_flag_reg
  import fx_flag_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  upd,
  input  nzcv_t nxt,
  output nzcv_t cur
);
  always_ff @(posedge clk) begin
    if (rst)      cur <= '0;
    else if (upd) cur <= nxt;
  end

  // R3: no set-flags, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(cur));

  // R3: set-flags captures the presented flags
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    upd |=> (cur == $past(nxt)));

  // R10: synchronous clear
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (cur == 4'b0000));

endmodule

// File: rtl/fx_cond_eval.sv
`timescale 1ns/1ps
module fx_cond_eval
  import fx_flag_pkg::*;
(
  input  logic [3:0] code,
  input  nzcv_t      f,
  output logic       taken
);
  assign taken = cond_holds(code, f);

  // R9: codes 14 and 15 always hold; EQ and NE are complementary on Z
  always_comb begin
    if (code[3:1] == 3'b111) a_r9_always: assert (taken);
    if (code == 4'd0)        a_r9_eq_z:   assert (taken == f.z);
    if (code == 4'd1)        a_r9_ne_z:   assert (taken == ~f.z);
  end

endmodule

// File: rtl/fx_flag_alu.sv
`timescale 1ns/1ps
module fx_flag_alu
  import fx_flag_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      op_sel,
  input  logic            set_flags,
  input  logic            w32,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic            dst_zr,
  input  logic [3:0]      cond,
  output logic [XLEN-1:0] res,
  output logic            wr_en,
  output logic [3:0]      flags,
  output logic            cond_true
);
  nzcv_t flg_nxt;
  nzcv_t flg_cur;
  logic  logic_op_evt;

  fx_arith #(.XLEN(XLEN)) u_arith (
    .op          (alu_op_e'(op_sel)),
    .w32         (w32),
    .a           (opnd_a),
    .b           (opnd_b),
    .res         (res),
    .flg_nxt     (flg_nxt),
    .is_logic_op (logic_op_evt)
  );

  fx_flag_reg u_flags (
    .clk (clk),
    .rst (rst),
    .upd (set_flags),
    .nxt (flg_nxt),
    .cur (flg_cur)
  );

  fx_cond_eval u_cond (
    .code  (cond),
    .f     (flg_cur),
    .taken (cond_true)
  );

  assign wr_en = ~dst_zr;
  assign flags = flg_cur;

  // R8: zero-register destination never writes back
  always_comb begin
    if (dst_zr) a_r8_no_write: assert (!wr_en);
  end

  // R6: a flag-setting AND leaves C and V clear
  a_r6_and_clears_cv: assert property (@(posedge clk) disable iff (rst)
    (set_flags && logic_op_evt) |=> (flags[1:0] == 2'b00));

endmodule

// File: tb/fx_flag_alu_bench.sv
`timescale 1ns/1ps
module fx_flag_alu_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  op_sel;
  logic        set_flags;
  logic        w32;
  logic [63:0] opnd_a;
  logic [63:0] opnd_b;
  logic        dst_zr;
  logic [3:0]  cond;
  logic [63:0] res;
  logic        wr_en;
  logic [3:0]  flags;
  logic        cond_true;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fx_flag_alu u_fx_flag_alu (
    .clk(clk), .rst(rst), .op_sel(op_sel), .set_flags(set_flags), .w32(w32),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .dst_zr(dst_zr), .cond(cond),
    .res(res), .wr_en(wr_en), .flags(flags), .cond_true(cond_true)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: returns {n,z,c,v,result}
  function automatic logic [67:0] model(input logic [1:0] op, input logic nar,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    logic n, z, c, v;
    logic [64:0] s65;
    longint sa, sb, s;
    if (op[1]) begin
      r = a & b;
      if (nar) r[63:32] = '0;
      c = 0; v = 0;
    end else if (nar) begin
      sa = longint'($signed(a[31:0]));
      sb = longint'($signed(b[31:0]));
      if (op[0]) begin
        r = {32'b0, a[31:0] - b[31:0]}; c = (a[31:0] >= b[31:0]); s = sa - sb;
      end else begin
        r = {32'b0, a[31:0] + b[31:0]};
        c = ({1'b0, a[31:0]} + {1'b0, b[31:0]}) > 33'h0_FFFF_FFFF; s = sa + sb;
      end
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      if (op[0]) begin
        r = a - b; c = (a >= b);
        s65 = {a[63], a} - {b[63], b};
      end else begin
        r = a + b; c = ({1'b0, a} + {1'b0, b}) > 65'h0_FFFF_FFFF_FFFF_FFFF;
        s65 = {a[63], a} + {b[63], b};
      end
      v = s65[64] ^ s65[63];
    end
    n = nar ? r[31] : r[63];
    z = (r == 0);
    return {n, z, c, v, r};
  endfunction

  function automatic logic cond_model(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0: return z;        4'd1: return !z;
      4'd2: return c;        4'd3: return !c;
      4'd4: return n;        4'd5: return !n;
      4'd6: return v;        4'd7: return !v;
      4'd8: return c && !z;  4'd9: return !c || z;
      4'd10: return n == v;  4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  // Issue one operation; check result now and flags after the edge.
  task automatic do_op(input string req, input logic [1:0] op, input logic sf,
                       input logic nar, input logic [63:0] a, input logic [63:0] b,
                       input logic dz, input logic [3:0] exp_flags);
    logic [67:0] m;
    m = model(op, nar, a, b);
    @(negedge clk);
    op_sel = op; set_flags = sf; w32 = nar; opnd_a = a; opnd_b = b; dst_zr = dz;
    #1;
    check({req, " res"}, res, m[63:0]);
    check({req, " wr_en R8"}, {63'b0, wr_en}, {63'b0, !dz});
    @(posedge clk);
    #1;
    set_flags = 0;
    check({req, " flags"}, {60'b0, flags}, {60'b0, exp_flags});
  endtask

  task automatic sweep_cond(input string req);
    for (int k = 0; k < 16; k++) begin
      cond = k[3:0];
      #0.2;
      check({req, " cond R9 R11"}, {63'b0, cond_true}, {63'b0, cond_model(k[3:0], flags)});
    end
  endtask

  task automatic t_reset();
    rst = 1; @(posedge clk); #1; rst = 0;
    check("R10 reset flags", {60'b0, flags}, 64'h0);
    cond = 4'd0; #0.2; check("R10 EQ after reset", {63'b0, cond_true}, 64'h0);
    cond = 4'd14; #0.2; check("R9 always", {63'b0, cond_true}, 64'h1);
  endtask

  task automatic t_arith();
    logic [67:0] m;
    m = model(2'b00, 0, 64'd40, 64'd2);
    do_op("R1 R2 add", 2'b00, 1, 0, 64'd40, 64'd2, 1'b0, m[67:64]);
    m = model(2'b01, 0, 64'd5, 64'd6);
    do_op("R5 sub negative", 2'b01, 1, 0, 64'd5, 64'd6, 1'b0, m[67:64]);
    check("R4 N from sub", {63'b0, flags[3]}, 64'h1);
    cond = 4'd4; #0.2; check("R11 MI", {63'b0, cond_true}, 64'h1);
    cond = 4'd5; #0.2; check("R11 PL", {63'b0, cond_true}, 64'h0);
    do_op("R5 add overflow", 2'b00, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 4'b1001);
    do_op("R5 add carry zero", 2'b00, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 4'b0110);
    do_op("R5 sub signed ovf", 2'b01, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 1'b0, 4'b0011);
  endtask

  task automatic t_compare_hold();
    do_op("R8 cmp equal", 2'b01, 1, 0, 64'd1234, 64'd1234, 1'b1, 4'b0110);
    cond = 4'd0; #0.2; check("R11 EQ after cmp", {63'b0, cond_true}, 64'h1);
    do_op("R3 hold add", 2'b00, 0, 0, 64'hF000_0000_0000_0000, 64'hF000_0000_0000_0000, 1'b0, 4'b0110);
    do_op("R3 hold sub", 2'b01, 0, 0, 64'd1, 64'd9, 1'b1, 4'b0110);
    cond = 4'd1; #0.2; check("R3 NE still false", {63'b0, cond_true}, 64'h0);
  endtask

  task automatic t_and();
    do_op("R5 set CV", 2'b00, 1, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 4'b0111);
    do_op("R6 ands", 2'b10, 1, 0, 64'hF0F0_0000_0000_0001, 64'h8000_0000_0000_0003, 1'b0, 4'b1000);
    do_op("R6 R2 tst op11 zero", 2'b11, 1, 0, 64'h0F, 64'hF0, 1'b1, 4'b0100);
  endtask

  task automatic t_w32();
    do_op("R7 w32 wrap", 2'b00, 1, 1, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_0000_0001, 1'b0, 4'b0110);
    do_op("R7 w32 ovf", 2'b00, 1, 1, 64'h0000_0001_7FFF_FFFF, 64'd1, 1'b0, 4'b1001);
    do_op("R7 w32 sub borrow", 2'b01, 1, 1, 64'hFFFF_FFFF_0000_0002, 64'd3, 1'b0, 4'b1000);
    do_op("R7 w32 and", 2'b10, 1, 1, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0000, 1'b0, 4'b1000);
  endtask

  task automatic t_cond();
    do_op("R9 flags 0000", 2'b00, 1, 0, 64'd1, 64'd1, 1'b0, 4'b0000);
    sweep_cond("flags 0000");
    do_op("R9 flags 1001", 2'b00, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 4'b1001);
    sweep_cond("flags 1001");
    do_op("R9 flags 0110", 2'b01, 1, 0, 64'd7, 64'd7, 1'b0, 4'b0110);
    sweep_cond("flags 0110");
    do_op("R9 flags 0010", 2'b01, 1, 0, 64'd9, 64'd7, 1'b0, 4'b0010);
    sweep_cond("flags 0010");
    do_op("R9 flags 1000", 2'b01, 1, 0, 64'd1, 64'd2, 1'b0, 4'b1000);
    sweep_cond("flags 1000");
  endtask

  initial begin
    rst = 1; op_sel = 0; set_flags = 0; w32 = 0; opnd_a = 0; opnd_b = 0;
    dst_zr = 0; cond = 0;
    @(posedge clk); #1;
    t_reset();
    t_arith();
    t_compare_hold();
    t_and();
    t_w32();
    t_cond();
    do_op("R10 dirty", 2'b01, 1, 0, 64'd1, 64'd2, 1'b0, 4'b1000);
    t_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule